// File: doc/BRIEF.md
# LCD Frame Store

This block is a slave on a 32-bit register bus. It captures drawing traffic meant for a 128 x 64 monochrome panel and keeps that traffic in a 1 KB video memory. The memory is split into 8 pages. Each page holds 128 column bytes, and each byte covers eight vertically stacked pixels.

Software first writes a mode word, which puts the block into data mode or command mode. Page-select commands move a write cursor made of a page and a column. Every byte written in data mode goes to the cursor position, and the column then steps forward, wrapping inside the current page.

A separate pixel port serves a display scanner. The scanner presents a pixel coordinate and receives that pixel's on/off value one cycle later.

The mode logic is a three-state machine:
- **INVALID** is the reset state.
- **DATA** is entered by the data magic word.
- **COMMAND** is entered by the command magic word.

From any state, a mode write carrying the data magic word goes to DATA, the command magic word goes to COMMAND, and any other value goes to INVALID. Without a mode write, the state holds.

Top module: `lcd_frame_store`

## Requirements
- R1: After reset the mode is INVALID, the cursor is at page 0, column 0, the interrupt-control register is 0 and `reg_rdata` is 0. Video memory contents are undefined after reset.
- R2: Offset 0x180 is an interrupt-control register that keeps all 32 bits written to it. A read at offset 0x180 returns its value on `reg_rdata` one cycle after `reg_re`. A read at any other offset returns 0, including the mode (0x1AC), instruction (0x1BC) and data (0x1C0) offsets.
- R3: A write to offset 0x1AC selects the mode:
  - 0x00100011 selects DATA.
  - 0x00104011 selects COMMAND.
  - Any other value selects INVALID.
  - Mode writes do not move the cursor.
- R4: In INVALID mode, writes to the data offset 0x1C0 change neither the video memory nor the cursor.
- R5: Writing a value from 0xB0 to 0xB7 to the instruction offset 0x1BC sets the page to (value − 0xB0) and the column to 0. This works in any mode. Other instruction values leave the cursor unchanged.
- R6: In COMMAND mode, a data-offset write of 0xB0 to 0xB7 selects page (value − 0xB0) and column 0. Any other value leaves the page, the column and the memory unchanged.
- R7: In DATA mode, a data-offset write stores `reg_wdata[7:0]` at byte address page*128 + column. The column then becomes (column + 1) mod 128, and the page stays the same.
- R8: `pix_lit` is bit (y mod 8) of byte x + (y div 8)*128, where a 1 means the pixel is lit. The value appears one cycle after `pix_x`/`pix_y` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_re` |
| pix_x | input | 7 | Pixel column, 0 to 127 |
| pix_y | input | 6 | Pixel row, 0 to 63 |
| pix_lit | output | 1 | Lit state of the addressed pixel, one cycle later |

## Verification
Register writes take effect at the rising edge that samples them. Both `reg_rdata` and `pix_lit` come out of one register stage, so their values are due one cycle after the strobe or coordinate is applied.

The bench drives every input on the falling edge and samples one full cycle later on the next falling edge. Every pixel check therefore sees memory that was written at least one edge earlier.

Ignored writes (invalid mode, unknown commands, out-of-range instructions) cannot be seen directly. Their effect is exposed by a following data-mode write: if the cursor was left alone, that write lands at the predicted address, and the bench reads the landed byte back through the pixel port.

// File: rtl/lcd_fs_pkg.sv
package lcd_fs_pkg;

    typedef enum logic [1:0] {
        MODE_INVALID = 2'd0,
        MODE_DATA    = 2'd1,
        MODE_CMD     = 2'd2
    } lcd_mode_e;

    localparam logic [31:0] MAGIC_DATA = 32'h0010_0011;
    localparam logic [31:0] MAGIC_CMD  = 32'h0010_4011;

endpackage

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_fs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [31:0] mode_word,
    output logic        data_mode,
    output logic        cmd_mode
);

    lcd_mode_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            if (mode_word == MAGIC_DATA)
                state_d = MODE_DATA;
            else if (mode_word == MAGIC_CMD)
                state_d = MODE_CMD;
            else
                state_d = MODE_INVALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_INVALID;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        data_mode = 1'b0;
        cmd_mode  = 1'b0;
        unique case (state_q)
            MODE_DATA: data_mode = 1'b1;
            MODE_CMD:  cmd_mode  = 1'b1;
            default: ;
        endcase
    end

    p_mode_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_word == MAGIC_DATA |=> data_mode && !cmd_mode);
    p_mode_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_word == MAGIC_CMD |=> cmd_mode && !data_mode);
    p_mode_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_word != MAGIC_DATA && mode_word != MAGIC_CMD
        |=> !data_mode && !cmd_mode);
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(data_mode) && $stable(cmd_mode));

endmodule

// File: rtl/lcd_cursor.sv
module lcd_cursor #(
    parameter  int COLS   = 128,
    parameter  int PAGES  = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_load,
    input  logic [PAGE_W-1:0] page_val,
    input  logic              advance,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (page_load) begin
            page <= page_val;
            col  <= '0;
        end else if (advance) begin
            col <= (col == LAST_COL) ? '0 : col + 1'b1;
        end
    end

    p_page_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        page_load |=> col == '0 && page == $past(page_val));
    p_col_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !page_load && col == LAST_COL |=> col == '0 && $stable(page));
    p_col_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !page_load && col != LAST_COL |=> col == $past(col) + 1'b1);

endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
    parameter  int COLS    = 128,
    parameter  int PAGES   = 8,
    localparam int DEPTH   = COLS * PAGES,
    localparam int VADDR_W = $clog2(DEPTH),
    localparam int COL_W   = $clog2(COLS),
    localparam int Y_W     = $clog2(PAGES * 8)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [VADDR_W-1:0] waddr,
    input  logic [7:0]         wbyte,
    input  logic [COL_W-1:0]   pix_x,
    input  logic [Y_W-1:0]     pix_y,
    output logic               pix_lit
);

    logic [7:0]         mem [DEPTH];
    logic [VADDR_W-1:0] raddr;
    logic [7:0]         rbyte;

    assign raddr = VADDR_W'(pix_y[Y_W-1:3]) * VADDR_W'(COLS) + VADDR_W'(pix_x);
    assign rbyte = mem[raddr];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wbyte;
        pix_lit <= rbyte[pix_y[2:0]];
    end

endmodule

// File: rtl/lcd_frame_store.sv
module lcd_frame_store
    import lcd_fs_pkg::*;
#(
    parameter  int ADDR_W        = 12,
    parameter  int COLS          = 128,
    parameter  int PAGES         = 8,
    parameter  int PAGE_CMD_BASE = 'hB0,
    localparam int COL_W         = $clog2(COLS),
    localparam int PAGE_W        = $clog2(PAGES),
    localparam int Y_W           = $clog2(PAGES * 8),
    localparam int VADDR_W       = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [31:0]       reg_rdata,
    input  logic [COL_W-1:0]  pix_x,
    input  logic [Y_W-1:0]    pix_y,
    output logic              pix_lit
);

    localparam logic [ADDR_W-1:0] OFS_IRQ  = ADDR_W'(12'h180);
    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(12'h1AC);
    localparam logic [ADDR_W-1:0] OFS_INST = ADDR_W'(12'h1BC);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h1C0);

    logic              wr_irq, wr_mode, wr_inst, wr_data;
    logic              data_mode, cmd_mode;
    logic              page_hit, page_load, advance;
    logic [PAGE_W-1:0] page_val, cur_page;
    logic [COL_W-1:0]  cur_col;
    logic [VADDR_W-1:0] waddr;
    logic [31:0]       irq_q;

    assign wr_irq  = reg_we && reg_addr == OFS_IRQ;
    assign wr_mode = reg_we && reg_addr == OFS_MODE;
    assign wr_inst = reg_we && reg_addr == OFS_INST;
    assign wr_data = reg_we && reg_addr == OFS_DATA;

    assign page_hit = reg_wdata >= 32'(PAGE_CMD_BASE) &&
                      reg_wdata <  32'(PAGE_CMD_BASE + PAGES);
    assign page_val = PAGE_W'(reg_wdata - 32'(PAGE_CMD_BASE));

    assign page_load = page_hit && (wr_inst || (wr_data && cmd_mode));
    assign advance   = wr_data && data_mode;
    assign waddr     = VADDR_W'(cur_page) * VADDR_W'(COLS) + VADDR_W'(cur_col);

    lcd_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (wr_mode),
        .mode_word (reg_wdata),
        .data_mode (data_mode),
        .cmd_mode  (cmd_mode)
    );

    lcd_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_load (page_load),
        .page_val  (page_val),
        .advance   (advance),
        .page      (cur_page),
        .col       (cur_col)
    );

    lcd_vram #(.COLS(COLS), .PAGES(PAGES)) u_vram (
        .clk     (clk),
        .we      (advance),
        .waddr   (waddr),
        .wbyte   (reg_wdata[7:0]),
        .pix_x   (pix_x),
        .pix_y   (pix_y),
        .pix_lit (pix_lit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q     <= '0;
            reg_rdata <= '0;
        end else begin
            if (wr_irq)
                irq_q <= reg_wdata;
            reg_rdata <= (reg_re && reg_addr == OFS_IRQ) ? irq_q : 32'd0;
        end
    end

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && reg_addr != OFS_IRQ |=> reg_rdata == 32'd0);
    p_invalid_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !data_mode && !cmd_mode |=> $stable(cur_page) && $stable(cur_col));
    p_cmd_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && cmd_mode && !page_hit |=> $stable(cur_page) && $stable(cur_col));
    p_inst_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inst && !page_hit |=> $stable(cur_page) && $stable(cur_col));

endmodule

// File: tb/lcd_frame_store_bench.sv
module lcd_frame_store_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic [6:0]  pix_x = '0;
    logic [5:0]  pix_y = '0;
    logic        pix_lit;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [1024];
    int m_page = 0;
    int m_col = 0;
    int m_mode = 0; // 0 invalid, 1 data, 2 command

    always #5 clk = ~clk;

    lcd_frame_store u_lcd_frame_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_lit   (pix_lit)
    );

    function automatic logic [7:0] pat(int p, int c);
        return 8'((p * 37 + c * 11 + 5) & 255);
    endfunction

    // Updates the bench model from the requirement text.
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h1AC) begin
            if (d == 32'h0010_0011) m_mode = 1;
            else if (d == 32'h0010_4011) m_mode = 2;
            else m_mode = 0;
        end else if (a == 12'h1BC) begin
            if (d >= 32'hB0 && d <= 32'hB7) begin m_page = int'(d) - 'hB0; m_col = 0; end
        end else if (a == 12'h1C0) begin
            if (m_mode == 1) begin
                model[m_page * 128 + m_col] = d[7:0];
                m_col = (m_col + 1) % 128;
            end else if (m_mode == 2 && d >= 32'hB0 && d <= 32'hB7) begin
                m_page = int'(d) - 'hB0; m_col = 0;
            end
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        model_write(a, d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic check_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%03h: actual 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic check_pix(input int x, input int y, input string tag);
        logic exp;
        exp = model[x + (y / 8) * 128][y % 8];
        pix_x = 7'(x); pix_y = 6'(y);
        @(negedge clk);
        checks++;
        if (pix_lit !== exp) begin
            errors++;
            $display("FAIL %s pixel (%0d,%0d): actual %b expected %b", tag, x, y, pix_lit, exp);
        end
    endtask

    task automatic check_byte(input int addr, input string tag);
        for (int b = 0; b < 8; b++)
            check_pix(addr % 128, (addr / 128) * 8 + b, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of read data and interrupt-control register
        checks++;
        if (reg_rdata !== 32'd0) begin
            errors++;
            $display("FAIL R1 rdata after reset: actual 0x%08h expected 0", reg_rdata);
        end
        check_read(12'h180, 32'd0, "R1");

        // R1: cursor starts at page 0 column 0, mode starts invalid
        bus_write(12'h1C0, 32'h0000_00FF);      // ignored in invalid mode
        bus_write(12'h1AC, 32'h0010_0011);
        bus_write(12'h1C0, 32'h0000_005A);      // lands at byte 0
        bus_write(12'h1C0, 32'h0000_00C3);      // lands at byte 1
        check_byte(0, "R1");
        check_byte(1, "R1");

        // R2: interrupt-control readback and unmapped offsets
        bus_write(12'h180, 32'hDEAD_BEEF);
        check_read(12'h180, 32'hDEAD_BEEF, "R2");
        check_read(12'h1AC, 32'd0, "R2");
        check_read(12'h1BC, 32'd0, "R2");
        check_read(12'h1C0, 32'd0, "R2");
        check_read(12'h000, 32'd0, "R2");
        bus_write(12'h180, 32'h0000_0001);
        check_read(12'h180, 32'h0000_0001, "R2");

        // R5 / R7: fill every page; the 129th write wraps onto column 0
        for (int p = 0; p < 8; p++) begin
            bus_write(12'h1BC, 32'(32'hB0 + p));
            for (int c = 0; c <= 128; c++)
                bus_write(12'h1C0, {24'hABCDEF, pat(p, c)});
        end

        // R8 / R7: sweep every pixel
        for (int y = 0; y < 64; y++)
            for (int x = 0; x < 128; x++)
                check_pix(x, y, "R8");

        // R3 / R4: invalid words (incl. near-magic) make data writes no-ops
        bus_write(12'h1AC, 32'h0010_0010);
        bus_write(12'h1C0, 32'h0000_0011);
        bus_write(12'h1AC, 32'h0000_0000);
        bus_write(12'h1C0, 32'h0000_0022);
        check_byte(7 * 128 + 1, "R4");
        bus_write(12'h1AC, 32'h0010_0011);      // R3: data mode, cursor untouched
        bus_write(12'h1C0, 32'h0000_0096);
        check_byte(7 * 128 + 1, "R3");
        check_byte(7 * 128 + 2, "R4");

        // R6: page select through the data register in command mode
        bus_write(12'h1AC, 32'h0010_4011);
        bus_write(12'h1C0, 32'h0000_00B2);
        bus_write(12'h1AC, 32'h0010_0011);
        bus_write(12'h1C0, 32'h0000_00A5);
        bus_write(12'h1C0, 32'h0000_003C);
        bus_write(12'h1AC, 32'h0010_4011);
        bus_write(12'h1C0, 32'h0000_0042);      // ignored
        bus_write(12'h1C0, 32'h0000_00B8);      // ignored
        bus_write(12'h1C0, 32'h0000_00AF);      // ignored
        bus_write(12'h1AC, 32'h0010_0011);
        bus_write(12'h1C0, 32'h0000_0077);
        check_byte(256, "R6");
        check_byte(257, "R6");
        check_byte(258, "R6");

        // R5: out-of-range instructions leave the cursor alone
        bus_write(12'h1BC, 32'h0000_00C0);
        bus_write(12'h1BC, 32'h0000_00AF);
        bus_write(12'h1C0, 32'h0000_0011);
        check_byte(259, "R5");
        bus_write(12'h1BC, 32'h0000_00B7);      // R5: works in data mode too
        bus_write(12'h1C0, 32'h0000_00E1);
        check_byte(7 * 128, "R5");

        // R7 / R8: final full sweep after mixed traffic
        for (int y = 0; y < 64; y++)
            for (int x = 0; x < 128; x++)
                check_pix(x, y, "R7");

        finish_run();
    end

endmodule